// File: doc/BRIEF.md
# Translation Lookaside Buffer with Whole-Buffer Flush

This block is a small, fully associative cache of address translations. Each entry pairs a 20-bit virtual page number with a 20-bit physical frame number and a valid flag. A lookup presents a 32-bit virtual address. The upper 20 bits are compared against every stored page number at the same time. On a hit, the stored frame number takes the place of the page number, and the low 12 offset bits pass through unchanged to form the physical address.

When no valid entry matches, the block reports a miss. The requester then fetches the mapping from the page table in memory and writes it back through the refill port. The next lookup of that page hits. When the processor switches to another process context, the flush input empties the whole buffer in one cycle. The entry count is a parameter, meant for values from 8 to 2048.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, and rsp_valid, rsp_hit, rsp_miss, rsp_pfn and rsp_paddr are all zero. A lookup made after reset with no refill misses.
- R2: A lookup request in one cycle raises rsp_valid in the next cycle. rsp_valid is low in any cycle that does not follow a request.
- R3: While rsp_valid is high, exactly one of rsp_hit and rsp_miss is high. While rsp_valid is low, both are low.
- R4: On a hit, rsp_pfn is the stored frame number. rsp_paddr bits 31:12 equal that frame number and bits 11:0 equal bits 11:0 of the looked-up virtual address.
- R5: On a miss, rsp_pfn and rsp_paddr are zero, so an invalid or absent page never yields a physical address.
- R6: A flush invalidates every entry, so all previously loaded pages miss afterwards. A refill in the same cycle as a flush is dropped.
- R7: A refill whose page number already sits in a valid entry overwrites that entry's frame number in place. At most one entry ever matches a page number.
- R8: A refill of a new page number fills the lowest-index invalid entry, so entries fill in index order after a flush or reset.
- R9: When all entries are valid, a refill of a new page evicts the entry named by a round-robin pointer. The pointer starts at entry 0, advances by one on each such eviction, wraps after the last entry, and returns to 0 on flush.
- R10: A lookup in the same cycle as a refill or a flush is answered from the contents held before that cycle's update.
- R11: Only entries whose valid flag is set can match. Comparisons against all entries happen in parallel within the single lookup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| rf_en | input | 1 | Refill write enable |
| rf_vpn | input | 20 | Page number to install |
| rf_pfn | input | 20 | Frame number to install |
| flush | input | 1 | Invalidate all entries (context switch) |
| rsp_valid | output | 1 | Lookup result valid, one cycle after lk_req |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; page table fetch needed |
| rsp_pfn | output | 20 | Frame number on a hit, else zero |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |

## Verification
The hardest state to reach is a full buffer whose replacement order shows through the ports. Entry indices are never visible, so victim choice can only be inferred from which older pages start to miss. Directed sequences fill every entry with distinct pages, add more pages, and then probe all originals. The same sequence runs again after a flush to show that the pointer restarted. Seeded random traffic then draws page numbers from a pool slightly larger than the entry count. This mixes refills, lookups and occasional flushes, including same-cycle collisions, and forces repeated evictions and re-refills of pages already present.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        pfn_t             pfn;
        logic [PA_W-1:0]  paddr;
    } tlb_rsp_t;

    function automatic logic [PA_W-1:0] join_addr(pfn_t f, off_t o);
        return {f, o};
    endfunction

    function automatic vpn_t page_of(logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic off_t offset_of(logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  tlb_entry_t [ENTRIES-1:0] ents,
    input  vpn_t                     key,
    output logic [ENTRIES-1:0]       hit_vec,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         hit_idx,
    output pfn_t                     hit_pfn
);
    // One comparator per entry, all evaluated together
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == key);
    end

    assign any_hit = |hit_vec;

    // Single-match guaranteed by refill policy, so an OR-mux suffices
    always_comb begin
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
                hit_pfn = hit_pfn | ents[i].pfn;
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign victim = any_free ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rr_ptr <= '0;
        end else if (alloc && !any_free) begin
            if (rr_ptr == IDX_W'(ENTRIES - 1))
                rr_ptr <= '0;
            else
                rr_ptr <= rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  vpn_t                     wr_vpn,
    input  pfn_t                     wr_pfn,
    output tlb_entry_t [ENTRIES-1:0] ents,
    output logic [ENTRIES-1:0]       valid_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ents[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ents[g].valid <= 1'b1;
                ents[g].vpn   <= wr_vpn;
                ents[g].pfn   <= wr_pfn;
            end
        end
        assign valid_vec[g] = ents[g].valid;
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             rf_en,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0] rf_pfn,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [PA_W-1:0]  rsp_paddr
);
    tlb_entry_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]       valid_vec;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    pfn_t               lk_pfn;

    logic [ENTRIES-1:0] rf_hit_vec;
    logic               rf_any;
    logic [IDX_W-1:0]   rf_idx;
    pfn_t               rf_old_pfn;

    logic [IDX_W-1:0]   victim;
    logic               wr_en;
    logic               alloc;
    logic [IDX_W-1:0]   wr_idx;
    tlb_rsp_t           rsp_q;

    // Lookup comparator bank
    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents    (ents),
        .key     (page_of(lk_vaddr)),
        .hit_vec (lk_hit_vec),
        .any_hit (lk_any),
        .hit_idx (lk_idx),
        .hit_pfn (lk_pfn)
    );

    // Refill comparator bank: finds an existing copy to overwrite
    tlb_match #(.ENTRIES(ENTRIES)) u_rf_match (
        .ents    (ents),
        .key     (rf_vpn),
        .hit_vec (rf_hit_vec),
        .any_hit (rf_any),
        .hit_idx (rf_idx),
        .hit_pfn (rf_old_pfn)
    );

    // Flush has priority over refill
    assign wr_en  = rf_en && !flush;
    assign alloc  = wr_en && !rf_any;
    assign wr_idx = rf_any ? rf_idx : victim;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .valid_vec (valid_vec),
        .alloc     (alloc),
        .victim    (victim)
    );

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (rf_vpn),
        .wr_pfn    (rf_pfn),
        .ents      (ents),
        .valid_vec (valid_vec)
    );

    // Registered response built from pre-update contents
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= lk_req;
            rsp_q.hit   <= lk_req && lk_any;
            rsp_q.miss  <= lk_req && !lk_any;
            rsp_q.pfn   <= (lk_req && lk_any) ? lk_pfn : '0;
            rsp_q.paddr <= (lk_req && lk_any) ? join_addr(lk_pfn, offset_of(lk_vaddr)) : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_pfn   = rsp_q.pfn;
    assign rsp_paddr = rsp_q.paddr;

    logic unused_ok;
    assign unused_ok = ^{lk_idx, rf_old_pfn};
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
)(
    input logic               clk,
    input logic               rst,
    input logic               lk_req,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic [PFN_W-1:0]   rsp_pfn,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [ENTRIES-1:0] match_vec
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid); // R2
    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss)); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R4
    AST_FRAME_JOIN: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_paddr[PA_W-1:OFF_W] == rsp_pfn); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0 && rsp_pfn == '0)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (flush ##1 lk_req) |=> rsp_miss); // R6
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec)); // R7
endmodule

bind tlb_cache tlb_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_pfn   (rsp_pfn),
    .rsp_paddr (rsp_paddr),
    .match_vec (lk_hit_vec)
);

// File: tb/tlb_cache_bench.sv
module tlb_cache_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [31:0] lk_vaddr;
    logic        rf_en;
    logic [19:0] rf_vpn;
    logic [19:0] rf_pfn;
    logic        flush;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [19:0] rsp_pfn;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Bench-side reference state
    logic        m_v   [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    int          m_ptr;

    always #2 clk = ~clk;

    tlb_cache #(.ENTRIES(N)) u_tlb_cache (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_pfn(rsp_pfn), .rsp_paddr(rsp_paddr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int model_find(input logic [19:0] vpn);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [19:0] f, input logic [11:0] o);
        return {f, o};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic model_refill(input logic [19:0] vpn, input logic [19:0] pfn);
        int idx;
        int first_free;
        idx = model_find(vpn);
        if (idx < 0) begin
            first_free = -1;
            for (int i = N - 1; i >= 0; i--)
                if (!m_v[i]) first_free = i;
            if (first_free >= 0) idx = first_free;
            else begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
    endtask

    // One cycle: drive at negedge, sample response at next negedge
    task automatic step(input bit lk, input logic [31:0] va, input bit rf,
                        input logic [19:0] rv, input logic [19:0] rp,
                        input bit fl, input string tag);
        int idx;
        bit e_hit;
        logic [19:0] e_pfn;
        logic [31:0] e_pa;
        lk_req = lk; lk_vaddr = va; rf_en = rf; rf_vpn = rv; rf_pfn = rp; flush = fl;
        idx = model_find(va[31:12]);
        e_hit = (idx >= 0);
        e_pfn = e_hit ? m_pfn[idx] : 20'h0;
        e_pa  = e_hit ? exp_paddr(e_pfn, va[11:0]) : 32'h0;
        @(negedge clk);
        if (lk) begin
            chk(rsp_valid == 1'b1, {tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
            chk(rsp_hit == e_hit && rsp_miss == !e_hit, {tag, " R3 hit/miss"},
                64'({rsp_hit, rsp_miss}), 64'({e_hit, !e_hit}));
            chk(rsp_paddr == e_pa && rsp_pfn == e_pfn, {tag, " R4/R5 paddr"},
                64'(rsp_paddr), 64'(e_pa));
        end else begin
            chk(rsp_valid == 1'b0, {tag, " R2 idle"}, 64'(rsp_valid), 64'd0);
        end
        if (fl) model_clear();
        else if (rf) model_refill(rv, rp);
        lk_req = 0; rf_en = 0; flush = 0;
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input string tag);
        step(1'b1, {vpn, off}, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input string tag);
        step(1'b0, '0, 1'b1, vpn, pfn, 1'b0, tag);
    endtask

    initial begin
        lk_req = 0; lk_vaddr = '0; rf_en = 0; rf_vpn = '0; rf_pfn = '0; flush = 0;
        rst = 1;
        model_clear();
        repeat (3) @(negedge clk);
        chk({rsp_valid, rsp_hit, rsp_miss} == 3'b000 && rsp_paddr == '0 && rsp_pfn == '0,
            "R1 reset outputs", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_paddr}), 64'd0);
        rst = 0;
        lookup(20'h00000, 12'h000, "R1 empty");
        lookup(20'h12345, 12'h678, "R1 empty");

        // Basic refill then hit, offset passthrough
        refill(20'h00010, 20'hABCDE, "R4");
        lookup(20'h00010, 12'hFFF, "R4");
        lookup(20'h00010, 12'h001, "R4");
        lookup(20'h00011, 12'h001, "R5");

        // Same-cycle lookup and refill: old contents answer
        step(1'b1, {20'h00020, 12'h123}, 1'b1, 20'h00020, 20'h00777, 1'b0, "R10 refill");
        lookup(20'h00020, 12'h123, "R10");

        // Overwrite existing page in place
        refill(20'h00010, 20'h11111, "R7");
        lookup(20'h00010, 12'h0A0, "R7");

        // Same-cycle lookup and flush: old contents answer; then empty
        step(1'b1, {20'h00010, 12'h055}, 1'b0, '0, '0, 1'b1, "R10 flush");
        lookup(20'h00010, 12'h055, "R6");
        lookup(20'h00020, 12'h055, "R6");

        // Flush beats same-cycle refill
        step(1'b0, '0, 1'b1, 20'h00030, 20'h00333, 1'b1, "R6 collide");
        lookup(20'h00030, 12'h000, "R6");

        // Fill all entries, then evict in round-robin order
        for (int i = 0; i < N; i++) refill(20'h00100 + 20'(i), 20'h0A000 + 20'(i), "R8");
        for (int i = 0; i < N; i++) lookup(20'h00100 + 20'(i), 12'h3C3, "R8");
        refill(20'h00200, 20'h0B000, "R9");
        refill(20'h00201, 20'h0B001, "R9");
        for (int i = 0; i < N; i++) lookup(20'h00100 + 20'(i), 12'h111, "R9");
        lookup(20'h00200, 12'h222, "R9");
        lookup(20'h00201, 12'h222, "R11");

        // Pointer restarts after flush
        step(1'b0, '0, 1'b0, '0, '0, 1'b1, "R9 flush");
        for (int i = 0; i < N; i++) refill(20'h00300 + 20'(i), 20'h0C000 + 20'(i), "R9");
        refill(20'h00400, 20'h0D000, "R9");
        for (int i = 0; i < 4; i++) lookup(20'h00300 + 20'(i), 12'h444, "R9");

        // Seeded random traffic
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 4000; k++) begin
            bit lk, rf, fl;
            logic [19:0] vp;
            lk = ($urandom % 10) < 7;
            rf = ($urandom % 10) < 4;
            fl = ($urandom % 100) < 2;
            vp = 20'h00500 + 20'($urandom % 24);
            step(lk, {20'h00500 + 20'($urandom % 24), 12'($urandom)}, rf, vp,
                 20'($urandom), fl, "R11 rand");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule